// File: doc/BRIEF.md
# SECDED Protected Dual-Clock Memory with Test Modes

This block is a synchronous memory whose words carry 64 data bits and 8 check bits under a single-error-correct, double-error-detect code. It has a write port on its own clock and a read port on its own clock. A read returns the data with any single-bit fault corrected. It also returns the stored check byte unchanged, plus two flags: one for a corrected single error and one for a detected double error.

A two-bit mode input selects how the memory behaves. Protected mode encodes every write and decodes every read. Encode-only mode encodes every write and shows the generated check byte on a write-side output, so the memory can serve as a check-byte generator; reads in this mode return the stored word raw. Decode-only mode stores whatever 72 bits are supplied and decodes them on read. To inject a fault, read a word, flip one or two bits, write it back in decode-only mode, and read it again.

A parameter places an optional register after the decoder. It adds one read-clock cycle to the data, check and flag outputs.

Top module: `secded_ram`

## Requirements
- R1: A stored word is 72 bits: data in bits 63:0 and check bits in 71:64. Lay out the Hamming positions 1 to 71. Check bit k (k = 0..6) sits at position 2^k. Data bit i sits at the (i+1)-th position that is not a power of two. Check bit k makes the XOR of the positions of all set bits zero in bit k. Check bit 7 gives even parity over the 64 data bits and check bits 0 to 6.
- R2: In protected mode (mode = 0, and also mode = 3), writes store internally generated check bits and ignore `wr_chk`. Reads return the stored check byte on `rd_chk`.
- R3: On a read in protected or decode-only mode, if exactly one data bit is wrong, `rd_data` returns the corrected value and `sgl_err` is 1.
- R4: On a read, if exactly one check bit is wrong (including check bit 7), `rd_data` equals the stored data and `sgl_err` is 1.
- R5: On a read, if exactly two bits of the 72 are wrong, `dbl_err` is 1, `sgl_err` is 0, and `rd_data` returns the stored data without correction.
- R6: `sgl_err` and `dbl_err` are never 1 in the same cycle.
- R7: In encode-only mode (mode = 1), a write places the check byte of `wr_data` on `par_out` after that write-clock edge. `par_out` holds its value through any cycle without an encode-only write.
- R8: A read in encode-only mode returns the stored 72 bits raw on `rd_data`/`rd_chk`, with both flags 0.
- R9: In decode-only mode (mode = 2), a write stores `{wr_chk, wr_data}` unchanged. `rd_chk` returns these check bits as written.
- R10: With OUT_REG = 0, read results appear after the read-clock edge that samples `rd_en`. With OUT_REG = 1, they appear one read-clock cycle later, with flags aligned to the data.
- R11: The flags are 0 in every cycle that does not carry a read result. Reset drives both flags and `par_out` to 0 at once.
- R12: With no read for two consecutive read-clock edges, `rd_data` and `rd_chk` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low async reset, write domain |
| mode | input | 2 | 0 protected, 1 encode-only, 2 decode-only, 3 as 0 |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_chk | input | CHK_W | Check byte to store in decode-only mode |
| par_out | output | CHK_W | Check byte from the last encode-only write |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low async reset, read domain |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected (or raw) read data |
| rd_chk | output | CHK_W | Stored check byte of the word read |
| sgl_err | output | 1 | Single error corrected |
| dbl_err | output | 1 | Double error detected |

## Verification
The bench injects single faults into the lowest and highest data bits, into check bit 0 and into the overall parity bit. If the decoder mapped syndromes to the wrong positions, it would flip a neighbouring bit. If it treated a fault in the overall parity bit as clean, it would leave `sgl_err` low. Double faults mix two data bits, a data bit with a check bit, and the overall bit with a data bit. A decoder that tried to correct these, or raised both flags, would produce wrong data. A garbage `wr_chk` in protected mode would show up on `rd_chk` if the input leaked through. Two instances with and without the output register are compared cycle by cycle, so a flag placed one cycle early or late is caught. `par_out` is checked for holding when no encode-only write occurs, and the flags are checked for clearing at reset while a faulty word is being read continuously.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_ENC  = 2'd1,
    MODE_DEC  = 2'd2
  } ecc_mode_e;

  // Hamming check-bit count for a data width
  function automatic int ham_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W:0]    chk_o
);

  localparam int POS_N = DATA_W + HAM_W;

  logic [POS_N:1]   cw;
  logic [HAM_W-1:0] ham;

  always_comb begin
    int di;
    di = 0;
    cw = '0;
    for (int p = 1; p <= POS_N; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = data_i[di];
        di++;
      end
    end
    ham = '0;
    for (int p = 1; p <= POS_N; p++) begin
      for (int k = 0; k < HAM_W; k++) begin
        if (((p >> k) & 1) == 1) ham[k] = ham[k] ^ cw[p];
      end
    end
    chk_o = {^{data_i, ham}, ham};
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = 7
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sgl_o,
  output logic              dbl_o
);

  localparam int POS_N = DATA_W + HAM_W;

  logic [POS_N:1]   cw;
  logic [POS_N:1]   fixed;
  logic [HAM_W-1:0] syn;
  logic             par_mis;
  logic             syn_nz;
  logic             syn_ok;

  // place data and check bits at their Hamming positions
  always_comb begin
    int di;
    di = 0;
    cw = '0;
    for (int p = 1; p <= POS_N; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = data_i[di];
        di++;
      end
    end
    for (int k = 0; k < HAM_W; k++) cw[1 << k] = chk_i[k];
  end

  always_comb begin
    syn = '0;
    for (int p = 1; p <= POS_N; p++) begin
      for (int k = 0; k < HAM_W; k++) begin
        if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ cw[p];
      end
    end
  end

  assign par_mis = ^{data_i, chk_i};
  assign syn_nz  = |syn;
  assign syn_ok  = (int'(syn) <= POS_N);

  // odd fault with a syndrome outside the word is uncorrectable
  assign sgl_o = par_mis && syn_ok;
  assign dbl_o = (!par_mis && syn_nz) || (par_mis && !syn_ok);

  always_comb begin
    int di;
    fixed = cw;
    for (int p = 1; p <= POS_N; p++) begin
      if (sgl_o && syn_nz && (int'(syn) == p)) fixed[p] = ~cw[p];
    end
    di = 0;
    data_o = '0;
    for (int p = 1; p <= POS_N; p++) begin
      if (!is_pow2(p)) begin
        data_o[di] = fixed[p];
        di++;
      end
    end
  end

endmodule

// File: rtl/secded_store.sv
module secded_store #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 72
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_comb begin
    word_d = word_q;
    if (rd_en) word_d = mem[rd_addr];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) word_q <= '0;
    else           word_q <= word_d;
  end

  assign rd_word = word_q;

endmodule

// File: rtl/secded_ram.sv
module secded_ram
  import secded_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 5,
  parameter int OUT_REG = 0,
  parameter int CHK_W   = secded_pkg::ham_bits(DATA_W) + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  output logic [CHK_W-1:0]  par_out,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic              sgl_err,
  output logic              dbl_err
);

  localparam int HAM_W  = CHK_W - 1;
  localparam int WORD_W = DATA_W + CHK_W;

  // ---------------- write side ----------------
  logic [CHK_W-1:0]  enc_chk;
  logic [WORD_W-1:0] wr_word;
  logic              raw_wr;
  logic              enc_wr;
  logic [CHK_W-1:0]  par_d;
  logic [CHK_W-1:0]  par_q;

  secded_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data_i (wr_data),
    .chk_o  (enc_chk)
  );

  assign raw_wr  = (mode == MODE_DEC);
  assign enc_wr  = wr_en && (mode == MODE_ENC);
  assign wr_word = raw_wr ? {wr_chk, wr_data} : {enc_chk, wr_data};

  always_comb begin
    par_d = par_q;
    if (enc_wr) par_d = enc_chk;
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) par_q <= '0;
    else           par_q <= par_d;
  end

  assign par_out = par_q;

  // ---------------- storage ----------------
  logic [WORD_W-1:0] word_q;

  secded_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  (wr_word),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_word  (word_q)
  );

  // ---------------- read side ----------------
  logic              vld_d, vld_q;
  logic              byp_d, byp_q;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sgl, dec_dbl;
  logic [DATA_W-1:0] s_data;
  logic [CHK_W-1:0]  s_chk;
  logic              s_sgl, s_dbl;

  always_comb begin
    vld_d = rd_en;
    byp_d = byp_q;
    if (rd_en) byp_d = (mode == MODE_ENC);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      vld_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      byp_q <= byp_d;
    end
  end

  secded_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .data_i (word_q[DATA_W-1:0]),
    .chk_i  (word_q[WORD_W-1:DATA_W]),
    .data_o (dec_data),
    .sgl_o  (dec_sgl),
    .dbl_o  (dec_dbl)
  );

  assign s_data = byp_q ? word_q[DATA_W-1:0] : dec_data;
  assign s_chk  = word_q[WORD_W-1:DATA_W];
  assign s_sgl  = vld_q && !byp_q && dec_sgl;
  assign s_dbl  = vld_q && !byp_q && dec_dbl;

  generate
    if (OUT_REG != 0) begin : g_oreg
      logic [DATA_W-1:0] o_data_q;
      logic [CHK_W-1:0]  o_chk_q;
      logic              o_sgl_q, o_dbl_q;

      always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
          o_data_q <= '0;
          o_chk_q  <= '0;
          o_sgl_q  <= 1'b0;
          o_dbl_q  <= 1'b0;
        end else begin
          o_data_q <= s_data;
          o_chk_q  <= s_chk;
          o_sgl_q  <= s_sgl;
          o_dbl_q  <= s_dbl;
        end
      end

      assign rd_data = o_data_q;
      assign rd_chk  = o_chk_q;
      assign sgl_err = o_sgl_q;
      assign dbl_err = o_dbl_q;
    end else begin : g_comb
      assign rd_data = s_data;
      assign rd_chk  = s_chk;
      assign sgl_err = s_sgl;
      assign dbl_err = s_dbl;
    end
  endgenerate

endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
  parameter int OUT_REG = 0,
  parameter int CHK_W   = 8
) (
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic [1:0]       mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             sgl_err,
  input logic             dbl_err,
  input logic [CHK_W-1:0] par_out,
  input logic [CHK_W-1:0] rd_chk
);

  logic en_d1, en_d2, en_late;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      en_d1 <= 1'b0;
      en_d2 <= 1'b0;
    end else begin
      en_d1 <= rd_en;
      en_d2 <= en_d1;
    end
  end

  assign en_late = (OUT_REG != 0) ? en_d2 : en_d1;

  AST_FLAGS_EXCL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(sgl_err && dbl_err)); // R6

  AST_IDLE_QUIET: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (sgl_err || dbl_err) |-> en_late); // R11

  AST_CHK_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_en && !en_d1) |=> $stable(rd_chk)); // R12

  AST_PAR_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !(wr_en && mode == 2'd1) |=> $stable(par_out)); // R7

endmodule

bind secded_ram secded_ram_chk #(.OUT_REG(OUT_REG), .CHK_W(CHK_W)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .mode     (mode),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .sgl_err  (sgl_err),
  .dbl_err  (dbl_err),
  .par_out  (par_out),
  .rd_chk   (rd_chk)
);

// File: tb/sim_secded_ram.sv
module sim_secded_ram;

  localparam int DW = 64;
  localparam int AW = 5;
  localparam int CW = 8;
  localparam int NV = 12;

  // {data, fault mask over {chk, data}}
  localparam logic [135:0] VEC [NV] = '{
    {64'h0123_4567_89AB_CDEF, 72'h00_0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 72'h00_0000_0000_0000_0000},
    {64'h0000_0000_0000_0000, 72'h00_0000_0000_0000_0000},
    {64'hDEAD_BEEF_CAFE_F00D, 72'h00_0000_0000_0000_0001},
    {64'h8000_0000_0000_0001, 72'h00_8000_0000_0000_0000},
    {64'h5555_AAAA_5555_AAAA, 72'h00_0000_0000_4000_0000},
    {64'h1357_9BDF_2468_ACE0, 72'h01_0000_0000_0000_0000},
    {64'hA5A5_5A5A_0F0F_F0F0, 72'h80_0000_0000_0000_0000},
    {64'h0000_0000_0000_0000, 72'h00_0000_0000_0000_0003},
    {64'h1111_2222_3333_4444, 72'h08_0000_0000_0000_0020},
    {64'hFEDC_BA98_7654_3210, 72'h80_0000_0000_0000_0400},
    {64'h0F0F_0F0F_0F0F_0F0F, 72'h03_0000_0000_0000_0000}
  };

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_chk;
  logic          rd_en;
  logic [AW-1:0] rd_addr;

  logic [CW-1:0] par0, par1;
  logic [DW-1:0] dat0, dat1;
  logic [CW-1:0] chk0, chk1;
  logic          sgl0, sgl1, dbl0, dbl1;

  int n_chk, n_bad;
  bit done;

  // captured read results
  logic [DW-1:0] c0_data, c1_data;
  logic [CW-1:0] c0_chk, c1_chk;
  logic          c0_sgl, c0_dbl, c1_sgl, c1_dbl;
  logic          e1_sgl, e1_dbl, l0_sgl, l0_dbl;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  secded_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(0)) u0 (
    .wr_clk(clk), .wr_rst_n(rst_n), .mode(mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk), .par_out(par0),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(dat0), .rd_chk(chk0), .sgl_err(sgl0), .dbl_err(dbl0)
  );

  secded_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1)) u1 (
    .wr_clk(clk), .wr_rst_n(rst_n), .mode(mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk), .par_out(par1),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(dat1), .rd_chk(chk1), .sgl_err(sgl1), .dbl_err(dbl1)
  );

  // reference check byte: low 7 bits are the XOR of the positions of set data bits
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] h;
    int n;
    h = '0;
    n = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[n]) h = h ^ 7'(p);
        n++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [CW-1:0] c);
    @(negedge clk);
    mode = m; wr_en = 1'b1; wr_addr = a; wr_data = d; wr_chk = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] m, input logic [AW-1:0] a);
    @(negedge clk);
    mode = m; rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    c0_data = dat0; c0_chk = chk0; c0_sgl = sgl0; c0_dbl = dbl0;
    e1_sgl = sgl1; e1_dbl = dbl1;
    @(negedge clk);
    c1_data = dat1; c1_chk = chk1; c1_sgl = sgl1; c1_dbl = dbl1;
    l0_sgl = sgl0; l0_dbl = dbl0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [71:0] m;
    logic [7:0]  rc;
    string       req;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; mode = 2'd0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wr_chk = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset flags u0", {70'd0, sgl0, dbl0}, 72'd0);
    check("R11", "reset flags u1", {70'd0, sgl1, dbl1}, 72'd0);
    check("R11", "reset par_out", {64'd0, par0}, 72'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      d  = VEC[i][135:72];
      m  = VEC[i][71:0];
      rc = ref_chk(d);
      if ($countones(m) == 0) begin
        req = "R1";
        do_write(2'd0, AW'(i), d, 8'h00);
        do_read(2'd0, AW'(i));
      end else begin
        req = ($countones(m) == 2) ? "R5" : ((m[71:64] != 0) ? "R4" : "R3");
        do_write(2'd2, AW'(i), d ^ m[63:0], rc ^ m[71:64]);
        do_read(2'd2, AW'(i));
      end
      check(req, "data u0", {8'd0, c0_data},
            {8'd0, ($countones(m) == 2) ? (d ^ m[63:0]) : d});
      check(req, "sgl u0", {71'd0, c0_sgl}, {71'd0, $countones(m) == 1});
      check(req, "dbl u0", {71'd0, c0_dbl}, {71'd0, $countones(m) == 2});
      check("R9", "chk u0", {64'd0, c0_chk}, {64'd0, rc ^ m[71:64]});
      check("R6", "flags exclusive", {71'd0, c0_sgl & c0_dbl}, 72'd0);
      check("R10", "u1 data delayed", {8'd0, c1_data}, {8'd0, c0_data});
      check("R10", "u1 flags delayed", {70'd0, c1_sgl, c1_dbl}, {70'd0, c0_sgl, c0_dbl});
      check("R11", "u0 flags idle", {70'd0, l0_sgl, l0_dbl}, 72'd0);
    end

    // R2: wr_chk ignored in protected mode
    do_write(2'd0, 5'd20, 64'hC0FF_EE00_1234_5678, 8'hA5);
    do_read(2'd0, 5'd20);
    check("R2", "generated chk", {64'd0, c0_chk}, {64'd0, ref_chk(64'hC0FF_EE00_1234_5678)});
    check("R2", "clean data", {8'd0, c0_data}, {8'd0, 64'hC0FF_EE00_1234_5678});
    check("R2", "no flags", {70'd0, c0_sgl, c0_dbl}, 72'd0);

    // R7: encode-only parity output, then hold
    do_write(2'd1, 5'd21, 64'h0BAD_F00D_DEAD_0001, 8'h00);
    check("R7", "par_out after write", {64'd0, par0}, {64'd0, ref_chk(64'h0BAD_F00D_DEAD_0001)});
    do_write(2'd0, 5'd22, 64'h1234, 8'h00);
    repeat (2) @(negedge clk);
    check("R7", "par_out held", {64'd0, par0}, {64'd0, ref_chk(64'h0BAD_F00D_DEAD_0001)});
    do_read(2'd1, 5'd21);
    check("R7", "encoded word readback", {c0_chk, c0_data},
          {ref_chk(64'h0BAD_F00D_DEAD_0001), 64'h0BAD_F00D_DEAD_0001});

    // R8: encode-only read bypasses decoding
    do_write(2'd2, 5'd23, 64'h0000_0000_0000_00F0 ^ 64'h4, ref_chk(64'hF0));
    do_read(2'd1, 5'd23);
    check("R8", "raw data", {8'd0, c0_data}, {8'd0, 64'hF4});
    check("R8", "no flags", {70'd0, c0_sgl, c0_dbl}, 72'd0);
    do_read(2'd2, 5'd23);
    check("R3", "same word decoded", {8'd0, c0_data}, {8'd0, 64'hF0});

    // R10: flag timing, u1 one cycle behind u0
    repeat (3) @(negedge clk);
    do_read(2'd2, 5'd3);
    check("R10", "u0 flag at first edge", {71'd0, c0_sgl}, 72'd1);
    check("R10", "u1 flag not yet", {70'd0, e1_sgl, e1_dbl}, 72'd0);
    check("R10", "u1 flag one later", {71'd0, c1_sgl}, 72'd1);

    // R12: outputs hold while idle
    repeat (4) @(negedge clk);
    check("R12", "data hold u0", {8'd0, dat0}, {8'd0, c0_data});
    check("R12", "chk hold u0", {64'd0, chk0}, {64'd0, c0_chk});
    check("R12", "data hold u1", {8'd0, dat1}, {8'd0, c1_data});

    // R11: reset clears flags during continuous faulty reads
    @(negedge clk);
    mode = 2'd2; rd_en = 1'b1; rd_addr = 5'd9;
    repeat (3) @(negedge clk);
    check("R5", "continuous dbl u0", {71'd0, dbl0}, 72'd1);
    check("R5", "continuous dbl u1", {71'd0, dbl1}, 72'd1);
    rst_n = 1'b0;
    #1;
    check("R11", "reset clears u0", {70'd0, sgl0, dbl0}, 72'd0);
    check("R11", "reset clears u1", {70'd0, sgl1, dbl1}, 72'd0);
    check("R11", "reset clears par_out", {64'd0, par0}, 72'd0);
    @(negedge clk);
    rd_en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule